// File: doc/BRIEF.md
# SPI Serial Clock Divider with Legacy and Extended Prescale Encodings

This block derives an SPI serial clock from the system clock. The division ratio comes from an 8-bit configuration byte. One input picks how that byte is read. The legacy reading gives even ratios from 4 to 30. The extended reading multiplies a 4-bit scalar by a power of two whose 3 exponent bits are scattered across the byte, which gives ratios from 1 to 1920, odd values included. Along with the clock level, the block drives one-cycle strobes that mark each rising and each falling serial-clock edge, so a neighbouring shift register can sample and launch data without detecting edges itself.

The block holds a copy of the decoded setting. It reloads that copy only while it is idle or on the last cycle of a serial-clock period. A software write that lands mid-period therefore never shortens or stretches the period already under way. A setting that cannot be decoded raises a flag and keeps the clock parked low.

Top module: `spi_sck_divider`

## Requirements
- R1: In extended mode (`extMode`=1), the divisor is S × 2^P. S is `cfgByte[3:0]`. P is `{cfgByte[7], cfgByte[6], cfgByte[4]}`, with `cfgByte[4]` as the least significant exponent bit. `cfgByte[5]` has no effect. The divisor can range from 1 to 1920.
- R2: In legacy mode (`extMode`=0), the divisor is twice `cfgByte[3:0]`, so it is even and lies between 4 and 30. `cfgByte[7:5]` have no effect.
- R3: The setting is illegal in these cases: in extended mode, S=0; in legacy mode, `cfgByte[4]`=0 or `cfgByte[3:0]`<2. `cfgBad` then goes high one cycle after the setting is sampled. While `cfgBad` is high, `sck` stays low and neither strobe fires.
- R4: For a divisor D≥2, each period begins with `sck` high for floor(D/2) cycles, then low for ceil(D/2) cycles. `sckRise` is high in the first high cycle of the period. `sckFall` is high in the first low cycle.
- R5: For D=1, `sck` stays low, and `sckRise` and `sckFall` are both high in every running cycle.
- R6: A change to `cfgByte` or `extMode` while running takes effect only after the current period ends. The next period then uses the new divisor in full.
- R7: While `runEn` is low, `sck` is low, no strobe fires, and the period counter restarts. The first period begins in the cycle after the clock edge that samples `runEn` high.
- R8: After reset, `sck`, `sckRise`, `sckFall` and `cfgBad` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extMode | input | 1 | 1 selects the extended encoding, 0 the legacy encoding |
| cfgByte | input | 8 | Prescale configuration byte |
| runEn | input | 1 | Enables serial clock generation |
| sck | output | 1 | Divided serial clock, idle low |
| sckRise | output | 1 | One-cycle strobe on a rising serial-clock edge |
| sckFall | output | 1 | One-cycle strobe on a falling serial-clock edge |
| cfgBad | output | 1 | The loaded setting is illegal |

## Verification
The bench targets five corner cases, and each one has a failure it would show:
- **Scattered exponent bits.** A decoder that took the exponent from contiguous bits, or that let bit 5 in, would give the wrong period for bytes such as 0xD3 and 0x2F.
- **Odd divisors.** A design that rounded the high phase up would get the duty split wrong.
- **Divide-by-1.** A design that left this case to the general counter would drop one of the two strobes or toggle `sck`.
- **Mid-period rewrites.** A design that reloaded immediately would produce a short runt period.
- **Illegal settings with `runEn` held high.** A design that failed to gate would keep clocking from a zero divisor.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
  localparam int SCK_CFG_W = 8;
  localparam int SCK_SPR_W = 4;
  localparam int SCK_PRE_W = 3;
  // largest divisor is (2^SPR_W - 1) << (2^PRE_W - 1)
  localparam int SCK_DIV_W = SCK_SPR_W + (1 << SCK_PRE_W) - 1;

  // control -> datapath strobes and the active timing values
  typedef struct packed {
    logic                 active;
    logic [SCK_DIV_W-1:0] div;
    logic [SCK_DIV_W-1:0] half;
  } sckCtl_t;
endpackage

// File: rtl/sckdiv_ctrl.sv
module sckdiv_ctrl
  import sckdiv_pkg::*;
#(
  parameter int CFG_W     = SCK_CFG_W,
  parameter int SPR_W     = SCK_SPR_W,
  parameter int PRE_W     = SCK_PRE_W,
  parameter int DIV_W     = SCK_DIV_W,
  parameter int PRE0_BIT  = 4,
  parameter int PREHI_LSB = 6,
  parameter int LEG_TAG   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extMode,
  input  logic [CFG_W-1:0] cfgByte,
  input  logic             runEn,
  input  logic             periodEnd,
  output sckCtl_t          ctl,
  output logic             cfgBad
);
  localparam logic [SPR_W-1:0] LEG_MIN = SPR_W'(2);
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(((1 << SPR_W) - 1) << ((1 << PRE_W) - 1));

  logic [SPR_W-1:0] extScalar;
  logic [PRE_W-1:0] extPow;
  logic [DIV_W-1:0] extDiv, legDiv, newDiv;
  logic             extBad, legBad, newBad;
  logic             unusedCfg;

  assign extScalar = cfgByte[SPR_W-1:0];
  assign extPow    = {cfgByte[PREHI_LSB +: PRE_W-1], cfgByte[PRE0_BIT]};
  assign extDiv    = DIV_W'(extScalar) << extPow;
  assign extBad    = (extScalar == '0);
  assign legDiv    = DIV_W'({cfgByte[SPR_W-1:0], 1'b0});
  assign legBad    = !cfgByte[LEG_TAG] || (cfgByte[SPR_W-1:0] < LEG_MIN);
  assign unusedCfg = cfgByte[5];

  always_comb begin
    if (extMode) begin
      newDiv = extDiv;
      newBad = extBad;
    end else begin
      newDiv = legDiv;
      newBad = legBad;
    end
  end

  logic             runQ, activeBad, active, loadNow;
  logic [DIV_W-1:0] activeDiv;

  assign active  = runQ && !activeBad;
  assign loadNow = !active || periodEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      activeDiv <= DIV_W'(1);
      activeBad <= 1'b0;
    end else begin
      runQ <= runEn;
      if (loadNow) begin
        activeDiv <= newDiv;
        activeBad <= newBad;
      end
    end
  end

  assign ctl.active = active;
  assign ctl.div    = activeDiv;
  assign ctl.half   = activeDiv >> 1;
  assign cfgBad     = activeBad;

  // R6: loaded divisor stays put inside a running period
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (active && !periodEnd) |=> $stable(activeDiv));
  // R1: an accepted divisor is within the legal span
  p_div_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (activeDiv != '0 && activeDiv <= DIV_MAX));
endmodule

// File: rtl/sckdiv_dp.sv
module sckdiv_dp
  import sckdiv_pkg::*;
#(
  parameter int DIV_W = SCK_DIV_W
) (
  input  logic    clk,
  input  logic    rstN,
  input  sckCtl_t ctl,
  output logic    periodEnd,
  output logic    sck,
  output logic    sckRise,
  output logic    sckFall
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;

  assign periodEnd = ctl.active && (cnt == ctl.div - ONE);

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (ctl.active && !periodEnd) cnt <= cnt + ONE;
    else cnt <= '0;
  end

  assign sck     = ctl.active && (cnt < ctl.half);
  assign sckRise = ctl.active && (cnt == '0);
  assign sckFall = ctl.active && (cnt == ctl.half);

  // R4: counter never walks past the loaded divisor
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |-> (cnt < ctl.div));
  // R4: a lone rise strobe is seen with sck high, a fall strobe with sck low
  p_rise_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sckRise && !sckFall) |-> sck);
  p_fall_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    sckFall |-> !sck);
  // R7: nothing moves while idle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.active |-> (!sck && !sckRise && !sckFall));
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
  import sckdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extMode,
  input  logic [7:0] cfgByte,
  input  logic       runEn,
  output logic       sck,
  output logic       sckRise,
  output logic       sckFall,
  output logic       cfgBad
);
  sckCtl_t ctl;
  logic    periodEnd;

  sckdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .extMode(extMode), .cfgByte(cfgByte),
    .runEn(runEn), .periodEnd(periodEnd), .ctl(ctl), .cfgBad(cfgBad)
  );

  sckdiv_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .periodEnd(periodEnd),
    .sck(sck), .sckRise(sckRise), .sckFall(sckFall)
  );

  // R3: an illegal setting keeps the serial clock parked
  p_bad_parked_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgBad |-> (!sck && !sckRise && !sckFall));
  // R5: both strobes together only for divide-by-1, with sck low
  p_div1_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sckRise && sckFall) |-> !sck);
endmodule

// File: tb/spi_sck_divider_bench.sv
module spi_sck_divider_bench;
  logic clk = 1'b0, rstN = 1'b0, extMode = 1'b0, runEn = 1'b0;
  logic [7:0] cfgByte = 8'h00;
  logic sck, sckRise, sckFall, cfgBad;
  int compared = 0, mismatched = 0;
  string curReq = "R8";

  always #10 clk = ~clk;

  spi_sck_divider u_spi_sck_divider (
    .clk(clk), .rstN(rstN), .extMode(extMode), .cfgByte(cfgByte),
    .runEn(runEn), .sck(sck), .sckRise(sckRise), .sckFall(sckFall), .cfgBad(cfgBad)
  );

  // divisor per R1/R2, legality per R3
  function automatic int expDiv(input bit ext, input logic [7:0] c, output bit bad);
    int s, p;
    if (ext) begin
      s = int'(c[3:0]);
      p = int'(c[7]) * 4 + int'(c[6]) * 2 + int'(c[4]);
      bad = (s == 0);
      return s << p;
    end
    bad = (c[4] == 1'b0) || (c[3:0] < 4'd2);
    return 2 * int'(c[3:0]);
  endfunction

  // cycle model built from R3..R7
  bit mRun = 0, mBad = 0;
  int mDiv = 1, mCnt = 0;
  always @(posedge clk) begin
    bit act, fin, nb;
    int nd;
    if (!rstN) begin
      mRun <= 0; mBad <= 0; mDiv <= 1; mCnt <= 0;
    end else begin
      act = mRun && !mBad;
      fin = act && (mCnt == mDiv - 1);
      nd  = expDiv(extMode, cfgByte, nb);
      if (!act || fin) begin mDiv <= nd; mBad <= nb; end
      mCnt <= (act && !fin) ? mCnt + 1 : 0;
      mRun <= runEn;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit act;
    @(posedge clk); #2;
    act = mRun && !mBad;
    chk("sck", sck, act && (mCnt < mDiv / 2));
    chk("sckRise", sckRise, act && (mCnt == 0));
    chk("sckFall", sckFall, act && (mCnt == mDiv / 2));
    chk("cfgBad", cfgBad, mBad);
  endtask

  // direct period/high-time measurement (R1, R2, R4, R5)
  task automatic measure(input bit ext, input logic [7:0] c, input string req);
    int per, highs, d, guard;
    bit bad;
    curReq = req;
    runEn = 0; extMode = ext; cfgByte = c;
    tick(); tick();
    runEn = 1;
    guard = 0;
    do begin tick(); guard++; end while (!sckRise && guard < 5000);
    highs = sck; per = 0;
    do begin
      tick(); per++;
      if (!sckRise) highs += sck;
    end while (!sckRise && per < 5000);
    d = expDiv(ext, c, bad);
    chk("period", per, d);
    chk("high time", highs, d / 2);
    runEn = 0; tick();
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int gap;
    void'($urandom(32'h5C4D1));
    repeat (3) @(posedge clk);
    #2;
    curReq = "R8";
    chk("reset sck", sck, 0); chk("reset rise", sckRise, 0);
    chk("reset fall", sckFall, 0); chk("reset bad", cfgBad, 0);
    rstN = 1;
    tick();

    measure(1, 8'h0F, "R1");
    measure(1, 8'h2F, "R1");   // bit5 ignored
    measure(1, 8'hD3, "R1");   // 3<<7 = 384
    measure(1, 8'h55, "R1");   // 5<<3 = 40
    measure(1, 8'h07, "R4");   // odd: 3 high, 4 low
    measure(1, 8'h19, "R4");   // 9<<1 = 18
    measure(0, 8'h12, "R2");   // 4
    measure(0, 8'hFF, "R2");   // 30, bits 7:5 ignored
    measure(0, 8'h17, "R2");
    measure(1, 8'h01, "R5");

    // R5: every running cycle has both strobes
    curReq = "R5";
    extMode = 1; cfgByte = 8'h01; runEn = 1;
    repeat (2) tick();
    repeat (6) begin tick(); chk("div1 rise", sckRise, 1); chk("div1 fall", sckFall, 1); chk("div1 sck", sck, 0); end

    // R3: illegal settings with runEn high
    curReq = "R3";
    cfgByte = 8'hF0; repeat (3) tick();
    chk("ext spr0 bad", cfgBad, 1); chk("ext spr0 sck", sck, 0);
    extMode = 0; cfgByte = 8'h0A; repeat (3) tick();
    chk("leg tag clear bad", cfgBad, 1);
    cfgByte = 8'h11; repeat (3) tick();
    chk("leg nib1 bad", cfgBad, 1); chk("leg nib1 rise", sckRise, 0);
    cfgByte = 8'h13; tick(); tick();
    chk("recovered", cfgBad, 0);

    // R6: rewrite mid-period, old period completes in full
    curReq = "R6";
    runEn = 0; extMode = 1; cfgByte = 8'h08; tick(); tick();
    runEn = 1;
    do tick(); while (!sckRise);
    tick(); tick(); tick();
    cfgByte = 8'h02;
    gap = 3;
    do begin tick(); gap++; end while (!sckRise && gap < 100);
    chk("old period kept", gap, 8);
    gap = 0;
    do begin tick(); gap++; end while (!sckRise && gap < 100);
    chk("new period", gap, 2);

    // R7: drop runEn, restart timing
    curReq = "R7";
    runEn = 0; tick(); tick();
    chk("idle sck", sck, 0); chk("idle rise", sckRise, 0);
    runEn = 1; tick();
    chk("first rise after enable", sckRise, 1);

    // random mix checked against the model
    for (int i = 0; i < 250; i++) begin
      bit ext;
      logic [7:0] c;
      int hold;
      ext = $urandom_range(0, 1);
      c = 8'($urandom);
      if ($urandom_range(0, 3) != 0) c[7] = 1'b0;
      if ($urandom_range(0, 3) != 0) c[6] = 1'b0;
      curReq = ext ? "R1" : "R2";
      extMode = ext; cfgByte = c;
      runEn = ($urandom_range(0, 7) != 0);
      hold = $urandom_range(1, 60);
      repeat (hold) tick();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule